// File: doc/BRIEF.md
# Stereo Peak Level Meter

This block watches a stream of stereo audio samples and keeps, for each channel, the largest absolute value seen since the last meter refresh. A falling edge on the refresh input closes the current interval. The held peak of each channel is turned into an 8-bit level code and placed on the outputs, and the tracking starts again from zero. The code is a logarithmic reading in whole decibels below full scale, with overrange and idle marks. As an alternative it can be a thermometer-style bar graph. A separate flag output reports whether each channel clipped during the closed interval. The left/right clock selects which channel's flag is shown.

Samples are 20-bit two's complement words that arrive with a one-cycle valid strobe, and both channels update together. The refresh input may come from another clock domain, so it is synchronized before its falling edge is detected. The code format is chosen once, at the first clock edge after reset is released. The decibel reading is obtained by comparing the held peak against a bank of precomputed thresholds spaced 1 dB apart. No logarithm is computed in hardware.

Top module: `peak_level_monitor`

## Requirements
- R1: Each channel independently holds the largest magnitude |x| of the samples accepted with `sampleValid` since the previous refresh. After a refresh, that channel's code encodes this maximum.
- R2: A refresh happens on a high-to-low transition of `updateIn`, seen after a two-flop synchronizer. It copies the encoded peaks to `leftCode`/`rightCode` and clears both held peaks. A rising edge, or a steady level, leaves the codes unchanged.
- R3: A sample accepted in the same clock cycle as a refresh belongs to the new interval. It does not appear in the codes produced by that refresh.
- R4: In log format, for a peak below full scale and not idle, bit 7 = 0, bit 6 = 0 and bits 5..0 = n. Here n is the number of whole dB steps k (1..60) for which the peak lies below FS·10^(-k/20), with FS = 2^19. That is, n = floor of the attenuation, within threshold rounding.
- R5: In log format, a peak below FS·10^(-3) gives code 0x7C (bit 6 set, bits 5..0 = 60). An interval with no samples gives the same code.
- R6: A peak of magnitude 2^19, which only the most negative sample produces, is overrange. It gives 0x80 in log format and 0xFF in bar format, and it sets that channel's flag.
- R7: In bar format, the codes are as follows, by attenuation band:
  - 0x7F: less than 3 dB
  - 0x3F: 3 to 6 dB
  - 0x1F: 6 to 10 dB
  - 0x0F: 10 to 20 dB
  - 0x07: 20 to 30 dB
  - 0x03: 30 to 40 dB
  - 0x01: 40 to 60 dB
  - 0x00: beyond 60 dB, or no samples
- R8: `barModeIn` (1 = bar format, 0 = log format) is sampled at the first rising clock edge after `rstN` rises. Later changes have no effect until the next reset.
- R9: `ovflOut` shows the left channel's overrange flag from the last refresh while `lrClk` is 1, and the right channel's flag while `lrClk` is 0.
- R10: While `rstN` is low, both codes are 0x00 and both overrange flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Both sample inputs carry a new stereo pair this cycle |
| leftSample | input | 20 | Left sample, two's complement |
| rightSample | input | 20 | Right sample, two's complement |
| updateIn | input | 1 | Refresh request; falling edge closes the interval (asynchronous) |
| barModeIn | input | 1 | Format select, 1 = bar graph, sampled once after reset |
| lrClk | input | 1 | Channel select for the flag output, 1 = left |
| leftCode | output | 8 | Left level code from the last refresh |
| rightCode | output | 8 | Right level code from the last refresh |
| ovflOut | output | 1 | Overrange flag of the channel chosen by `lrClk` |

## Verification
The hardest case to reach from the pins is a sample that lands in exactly the cycle in which the synchronized refresh edge fires. That cycle lies three clock edges after `updateIn` falls, so the stimulus counts falling clock edges from the drop and presents one large sample only for that cycle. It then checks that the first refresh still shows the small earlier peak, and that the following refresh shows the large one. A second hard spot is a peak sitting almost exactly on a decibel threshold. The bench takes its expected code from a floating-point logarithm and accepts either neighbouring code only within 0.05 dB of a step. Random log-distributed magnitudes, together with the only full-scale value (the most negative code), cover both formats.

// File: rtl/psm_pkg.sv
package psm_pkg;

  // Idle boundary and number of 1 dB steps in the log format
  localparam int DB_STEPS = 60;
  localparam int CODE_W   = 8;

  typedef struct packed {
    logic xfer;     // one-cycle refresh strobe
    logic barMode;  // held format select
  } psmCtrlT;

  // 10^(-j/20) in Q16 for j = 0..19
  function automatic longint unsigned mantQ16(input int j);
    case (j)
      0:  return 65536;
      1:  return 58409;
      2:  return 52057;
      3:  return 46396;
      4:  return 41350;
      5:  return 36854;
      6:  return 32846;
      7:  return 29274;
      8:  return 26090;
      9:  return 23253;
      10: return 20724;
      11: return 18471;
      12: return 16462;
      13: return 14672;
      14: return 13076;
      15: return 11654;
      16: return 10387;
      17: return 9257;
      18: return 8250;
      default: return 7353;
    endcase
  endfunction

  // Magnitude at k dB below full scale for a w-bit signed sample
  function automatic longint unsigned dbThreshold(input int k, input int w);
    longint unsigned scaled;
    longint unsigned div;
    scaled = ((longint'(1) << (w - 1)) * mantQ16(k % 20)) >> 16;
    div = 1;
    for (int i = 0; i < k / 20; i++) div = div * 10;
    return scaled / div;
  endfunction

endpackage

// File: rtl/psm_level_enc.sv
module psm_level_enc
  import psm_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic [SAMPLE_W-1:0] mag,
  input  logic                barMode,
  output logic [CODE_W-1:0]   code
);

  localparam int DEPTH_W = $clog2(DB_STEPS + 1);

  logic [DB_STEPS-1:0] below;
  logic [DEPTH_W-1:0]  depth;
  logic                overRange;

  // One comparator per dB step; the result is a thermometer
  for (genvar k = 0; k < DB_STEPS; k++) begin : g_thr
    localparam longint unsigned THR = dbThreshold(k + 1, SAMPLE_W);
    assign below[k] = 64'(mag) < THR;
  end

  always_comb begin
    depth = '0;
    for (int k = 0; k < DB_STEPS; k++) depth = depth + DEPTH_W'(below[k]);
  end

  // Full scale is 2^(W-1); only the most negative sample reaches it
  assign overRange = mag[SAMPLE_W-1];

  always_comb begin
    if (!barMode) begin
      if (overRange)                    code = 8'h80;
      else if (depth == DEPTH_W'(DB_STEPS)) code = {2'b01, 6'(DB_STEPS)};
      else                              code = {2'b00, 6'(depth)};
    end else begin
      if (overRange)                    code = 8'hFF;
      else if (depth < DEPTH_W'(3))     code = 8'h7F;
      else if (depth < DEPTH_W'(6))     code = 8'h3F;
      else if (depth < DEPTH_W'(10))    code = 8'h1F;
      else if (depth < DEPTH_W'(20))    code = 8'h0F;
      else if (depth < DEPTH_W'(30))    code = 8'h07;
      else if (depth < DEPTH_W'(40))    code = 8'h03;
      else if (depth < DEPTH_W'(DB_STEPS)) code = 8'h01;
      else                              code = 8'h00;
    end
  end

endmodule

// File: rtl/psm_ctrl.sv
module psm_ctrl
  import psm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    updateIn,
  input  logic    barModeIn,
  output psmCtrlT ctrl
);

  logic [2:0] updSync;
  logic       modeTaken;
  logic       barModeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updSync   <= '0;
      modeTaken <= 1'b0;
      barModeQ  <= 1'b0;
    end else begin
      updSync <= {updSync[1:0], updateIn};
      if (!modeTaken) begin
        barModeQ  <= barModeIn;
        modeTaken <= 1'b1;
      end
    end
  end

  assign ctrl.xfer    = updSync[2] & ~updSync[1];
  assign ctrl.barMode = barModeQ;

endmodule

// File: rtl/psm_datapath.sv
module psm_datapath
  import psm_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int CHANS    = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  psmCtrlT                        ctrl,
  input  logic                           sampleValid,
  input  logic [CHANS-1:0][SAMPLE_W-1:0] samples,
  output logic [CHANS-1:0][CODE_W-1:0]   codes,
  output logic [CHANS-1:0]               ovfl
);

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_ch
    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] peakQ;
    logic [CODE_W-1:0]   enc;

    assign mag = samples[ch][SAMPLE_W-1] ? (~samples[ch] + 1'b1) : samples[ch];

    psm_level_enc #(.SAMPLE_W(SAMPLE_W)) enc_i (
      .mag    (peakQ),
      .barMode(ctrl.barMode),
      .code   (enc)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        peakQ     <= '0;
        codes[ch] <= '0;
        ovfl[ch]  <= 1'b0;
      end else if (ctrl.xfer) begin
        codes[ch] <= enc;
        ovfl[ch]  <= peakQ[SAMPLE_W-1];
        peakQ     <= sampleValid ? mag : '0;
      end else if (sampleValid && (mag > peakQ)) begin
        peakQ <= mag;
      end
    end
  end

endmodule

// File: rtl/peak_level_monitor.sv
module peak_level_monitor
  import psm_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                updateIn,
  input  logic                barModeIn,
  input  logic                lrClk,
  output logic [CODE_W-1:0]   leftCode,
  output logic [CODE_W-1:0]   rightCode,
  output logic                ovflOut
);

  psmCtrlT                   ctrlS;
  logic [1:0][CODE_W-1:0]    codes;
  logic [1:0]                ovfl;

  psm_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .updateIn (updateIn),
    .barModeIn(barModeIn),
    .ctrl     (ctrlS)
  );

  psm_datapath #(.SAMPLE_W(SAMPLE_W), .CHANS(2)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlS),
    .sampleValid(sampleValid),
    .samples    ({rightSample, leftSample}),
    .codes      (codes),
    .ovfl       (ovfl)
  );

  assign leftCode  = codes[0];
  assign rightCode = codes[1];
  assign ovflOut   = lrClk ? ovfl[0] : ovfl[1];

endmodule

// File: rtl/psm_chk.sv
module psm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       xfer,
  input logic       barMode,
  input logic [7:0] leftCode,
  input logic [7:0] rightCode,
  input logic       ovflOut,
  input logic       lrClk
);

  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R2
  codes_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xfer |=> $stable({leftCode, rightCode}));

  // R2
  xfer_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    xfer |=> !xfer);

  // R6
  ovr_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!barMode && (leftCode[7] || rightCode[7])) |->
      ((!leftCode[7] || leftCode[6:0] == 7'd0) && (!rightCode[7] || rightCode[6:0] == 7'd0)));

  // R5
  idle_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!barMode && leftCode[6]) |-> (leftCode[5:0] == 6'd60 && !leftCode[7]));

  // R7
  bar_thermo_chk: assert property (@(posedge clk) disable iff (!rstN)
    barMode |-> (((leftCode & (leftCode + 8'd1)) == 8'd0) &&
                 ((rightCode & (rightCode + 8'd1)) == 8'd0)));

  // R8
  mode_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3) |-> $stable(barMode));

  // R9
  ovfl_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lrClk && upCnt == 2'd3) |-> (ovflOut == (barMode ? (leftCode == 8'hFF) : leftCode[7])));

  // R9
  ovfl_right_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lrClk && upCnt == 2'd3) |-> (ovflOut == (barMode ? (rightCode == 8'hFF) : rightCode[7])));

endmodule

bind peak_level_monitor psm_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .xfer     (ctrlS.xfer),
  .barMode  (ctrlS.barMode),
  .leftCode (leftCode),
  .rightCode(rightCode),
  .ovflOut  (ovflOut),
  .lrClk    (lrClk)
);

// File: tb/peak_level_monitor_tb_top.sv
module peak_level_monitor_tb_top;

  localparam int FS = 524288;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sampleValid;
  logic [19:0] leftSample, rightSample;
  logic        updateIn, barModeIn, lrClk;
  logic [7:0]  leftCode, rightCode;
  logic        ovflOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int maxL = 0, maxR = 0;
  int lastL = 0, lastR = 0;
  bit barNow = 0;

  always #5 clk = ~clk;

  peak_level_monitor dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .leftSample(leftSample), .rightSample(rightSample),
    .updateIn(updateIn), .barModeIn(barModeIn), .lrClk(lrClk),
    .leftCode(leftCode), .rightCode(rightCode), .ovflOut(ovflOut)
  );

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic logic [7:0] codeOf(input int n, input bit bar);
    if (!bar) return (n >= 60) ? 8'h7C : 8'(n);
    if (n < 3)  return 8'h7F;
    if (n < 6)  return 8'h3F;
    if (n < 10) return 8'h1F;
    if (n < 20) return 8'h0F;
    if (n < 30) return 8'h07;
    if (n < 40) return 8'h03;
    if (n < 60) return 8'h01;
    return 8'h00;
  endfunction

  function automatic int clampN(input real a);
    int n;
    n = int'($floor(a));
    if (n < 0) n = 0;
    if (n > 60) n = 60;
    return n;
  endfunction

  function automatic bit codeOk(input int mag, input bit bar, input logic [7:0] got,
                                output logic [7:0] e0);
    real att;
    logic [7:0] e1;
    if (mag >= FS) begin
      e0 = bar ? 8'hFF : 8'h80;
      return got == e0;
    end
    att = (mag == 0) ? 1000.0 : -20.0 * $log10(real'(mag) / real'(FS));
    e0 = codeOf(clampN(att - 0.05), bar);
    e1 = codeOf(clampN(att + 0.05), bar);
    return (got == e0) || (got == e1);
  endfunction

  task automatic checkCodes(input string tag);
    logic [7:0] e;
    checks++;
    if (!codeOk(lastL, barNow, leftCode, e)) begin
      errors++;
      $display("FAIL %s left code actual=%h expected=%h (mag %0d)", tag, leftCode, e, lastL);
    end
    checks++;
    if (!codeOk(lastR, barNow, rightCode, e)) begin
      errors++;
      $display("FAIL %s right code actual=%h expected=%h (mag %0d)", tag, rightCode, e, lastR);
    end
  endtask

  task automatic checkOvfl(input string tag);
    @(negedge clk); lrClk = 1'b1; #1;
    checks++;
    if (ovflOut !== (lastL >= FS)) begin
      errors++;
      $display("FAIL %s left flag actual=%b expected=%b", tag, ovflOut, lastL >= FS);
    end
    lrClk = 1'b0; #1;
    checks++;
    if (ovflOut !== (lastR >= FS)) begin
      errors++;
      $display("FAIL %s right flag actual=%b expected=%b", tag, ovflOut, lastR >= FS);
    end
  endtask

  task automatic putSample(input int l, input int r);
    @(negedge clk);
    sampleValid = 1'b1;
    leftSample  = 20'(l);
    rightSample = 20'(r);
    if (absv(l) > maxL) maxL = absv(l);
    if (absv(r) > maxR) maxR = absv(r);
  endtask

  task automatic fallUpdate();
    @(negedge clk); sampleValid = 1'b0; updateIn = 1'b0;
    repeat (6) @(negedge clk);
    lastL = maxL; lastR = maxR; maxL = 0; maxR = 0;
  endtask

  task automatic pulseUpdate();
    @(negedge clk); sampleValid = 1'b0; updateIn = 1'b1;
    repeat (2) @(negedge clk);
    fallUpdate();
  endtask

  function automatic int randSample();
    int m;
    m = $urandom_range(FS - 1, 0) >> $urandom_range(16, 0);
    if ($urandom_range(15, 0) == 0) return -FS;
    return $urandom_range(1, 0) ? -m : m;
  endfunction

  task automatic randomIntervals(input int count, input string tag);
    for (int i = 0; i < count; i++) begin
      int ns;
      ns = $urandom_range(6, 1);
      for (int s = 0; s < ns; s++) putSample(randSample(), randSample());
      pulseUpdate();
      checkCodes(tag);
      checkOvfl({tag, " R9"});
    end
  endtask

  task automatic checkReset(input string tag);
    checks++;
    if (leftCode !== 8'h00 || rightCode !== 8'h00) begin
      errors++;
      $display("FAIL %s reset codes actual=%h/%h expected=00/00", tag, leftCode, rightCode);
    end
    lastL = 0; lastR = 0;
    checks++;
    lrClk = 1'b1; #1;
    if (ovflOut !== 1'b0) begin
      errors++;
      $display("FAIL %s reset flag actual=%b expected=0", tag, ovflOut);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; sampleValid = 1'b0; leftSample = '0; rightSample = '0;
    updateIn = 1'b0; barModeIn = 1'b0; lrClk = 1'b0;
    repeat (4) @(negedge clk);
    checkReset("R10");
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); barModeIn = 1'b1;  // R8: must be ignored
    barNow = 0;

    // R5 empty interval gives idle code; R8 log format kept
    pulseUpdate();
    checkCodes("R5 R8");

    // R6 most negative code is overrange; positive max reads 0 dB
    putSample(-FS, FS - 1);
    pulseUpdate();
    checkCodes("R6 R4 R8");
    checkOvfl("R6 R9");

    // R4 directed depths: -6.02 dB and -20.4 dB
    putSample(262144, -50000);
    pulseUpdate();
    checkCodes("R4");

    // R2 rising edge and steady high leave codes alone
    @(negedge clk); updateIn = 1'b1;
    putSample(1000, -2000);
    @(negedge clk); sampleValid = 1'b0;
    repeat (4) @(negedge clk);
    checkCodes("R2 hold");
    fallUpdate();
    checkCodes("R2 transfer");

    // R3 sample in the transfer cycle goes to the new interval
    putSample(100, -100);
    @(negedge clk); sampleValid = 1'b0; updateIn = 1'b1;
    repeat (2) @(negedge clk);
    updateIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    sampleValid = 1'b1; leftSample = 20'(400000); rightSample = 20'(-300000);
    @(negedge clk); sampleValid = 1'b0;
    repeat (4) @(negedge clk);
    lastL = maxL; lastR = maxR; maxL = 400000; maxR = 300000;
    checkCodes("R3 old interval");
    pulseUpdate();
    checkCodes("R3 new interval");

    // R2 clear: a small interval after a large one
    putSample(5000, 7);
    pulseUpdate();
    checkCodes("R2 clear");

    randomIntervals(20, "R1 R4");

    // Second reset with bar format selected
    @(negedge clk); rstN = 1'b0; barModeIn = 1'b1;
    repeat (3) @(negedge clk);
    checkReset("R10 second");
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); barModeIn = 1'b0;  // R8: must be ignored
    barNow = 1;
    maxL = 0; maxR = 0;

    pulseUpdate();
    checkCodes("R7 empty R8");

    putSample(-FS, 500000);   pulseUpdate(); checkCodes("R7 R6"); checkOvfl("R6 R9 bar");
    putSample(300000, -200000); pulseUpdate(); checkCodes("R7");
    putSample(100000, 30000);   pulseUpdate(); checkCodes("R7");
    putSample(-10000, 2000);    pulseUpdate(); checkCodes("R7");
    putSample(300, 0);          pulseUpdate(); checkCodes("R7");

    randomIntervals(12, "R1 R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule